// File: doc/BRIEF.md
# Clock-Tracking Beep Tone Generator

This block makes the square wave for an audible key-click or alarm beep. A free-running counter advances once every two system clocks, and one of its bits, chosen by software through a one-hot select field, drives the beep line. Choosing a higher counter bit halves the pitch. A separate enable bit mutes or unmutes the tone without disturbing the counter.

The system clock can be scaled down to one half or one thirty-second of full speed. The block is told the current ratio and lowers the counter bit it uses to match, so the pitch heard stays about the same. A select field with several bits set uses the lowest one. An empty field keeps the line low.

A three-state machine decides what the output does. OFF holds the line low while the enable bit is clear. SILENT holds it low while enabled with an empty select field. TONE copies the chosen counter bit to the line. On every clock the machine moves to OFF when enable is clear ("mute"). It moves to SILENT when enable is set and the field is empty ("no pitch"). It moves to TONE when enable is set and the field is non-empty ("play"). Any state can reach any other in one step.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the beep output is low, the enable is clear, the select field is empty and the counter is zero.
- R2: A write with `wr_addr` = 0 loads the enable from `wr_data[0]`. The other data bits of that write have no effect.
- R3: A write with `wr_addr` = 1 loads the select field from `wr_data[18:10]`, where field bit i names counter bit 10+i. The other data bits of that write have no effect.
- R4: The counter advances by one every second clock. It keeps running whatever the enable, state or select field.
- R5: With ratio code 00 (full speed) and counter bit k selected, the output is high for 2^(k+1) clocks and low for 2^(k+1) clocks. Bit 10 gives a period of 4096 clocks.
- R6: Ratio code 01 (half speed) uses counter bit k-1. Ratio code 11 is treated as full speed.
- R7: Ratio code 10 (1/32 speed) uses counter bit k-5. A compensated index below zero is clamped to bit 0.
- R8: When the select field has more than one bit set, only the lowest set bit counts.
- R9: While enabled with an empty select field, the output stays low.
- R10: Clearing the enable forces the output low within two clocks of the write. The counter keeps running, so the tone resumes in its original phase when enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the bit-select register |
| wr_data | input | 32 | Write data |
| clk_ratio | input | 2 | Current clock-scaling code: 00 full, 01 half, 10 1/32, 11 treated as full |
| beep | output | 1 | Beep square wave |

## Verification
Almost every internal fault shows up as a wrong tone period. A counter that steps at the wrong rate, a wrong priority pick or a wrong ratio compensation all scale the measured high and low times by a power of two. The error is visible within one period of the expected tone. A counter that stops while the tone is muted is harder to see, because the pitch is still correct after unmuting. Only the phase of the first falling edge against an edge recorded before the mute exposes it. A state machine stuck in TONE shows up as edges in the two-clock window after a mute, or during an empty-field interval.

// File: rtl/beep_tone_pkg.sv
package beep_tone_pkg;

    typedef enum logic [1:0] {
        RATIO_FULL = 2'b00,
        RATIO_HALF = 2'b01,
        RATIO_SLOW = 2'b10,
        RATIO_RSVD = 2'b11
    } ratio_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_SILENT = 2'b01,
        ST_TONE   = 2'b10
    } tone_state_e;

    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_SELECT = 1'b1;

    localparam int unsigned HALF_SHIFT = 1;
    localparam int unsigned SLOW_SHIFT = 5;

endpackage

// File: rtl/beep_cfg_regs.sv
module beep_cfg_regs #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FIELD_LSB = 10,
    parameter int unsigned FIELD_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               en_q,
    output logic [FIELD_W-1:0] field_q
);
    import beep_tone_pkg::*;

    localparam int unsigned FIELD_MSB = FIELD_LSB + FIELD_W - 1;

    logic unused_rsvd;
    assign unused_rsvd = ^{wr_data[DATA_W-1:FIELD_MSB+1], wr_data[FIELD_LSB-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            field_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                en_q <= wr_data[0];
            end else begin
                field_q <= wr_data[FIELD_MSB:FIELD_LSB];
            end
        end
    end

endmodule

// File: rtl/beep_free_counter.sv
module beep_free_counter #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ph_q,
    output logic [CNT_W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/beep_bit_select.sv
module beep_bit_select #(
    parameter int unsigned FIELD_W   = 9,
    parameter int unsigned FIELD_LSB = 10,
    parameter int unsigned CNT_W     = 20,
    localparam int unsigned POS_W    = $clog2(FIELD_W),
    localparam int unsigned IDX_W    = $clog2(CNT_W)
) (
    input  logic [FIELD_W-1:0]      field,
    input  beep_tone_pkg::ratio_e   ratio,
    output logic [FIELD_W-1:0]      sel_onehot,
    output logic                    sel_valid,
    output logic [IDX_W-1:0]        idx
);
    import beep_tone_pkg::*;

    logic [POS_W-1:0] pos;
    int unsigned      base;
    int unsigned      shift;

    // isolate the lowest set bit
    assign sel_onehot = field & (~field + 1'b1);
    assign sel_valid  = |field;

    always_comb begin
        pos = '0;
        for (int i = 0; i < FIELD_W; i++) begin
            if (sel_onehot[i]) begin
                pos = pos | POS_W'(i);
            end
        end
    end

    always_comb begin
        unique case (ratio)
            RATIO_HALF: shift = HALF_SHIFT;
            RATIO_SLOW: shift = SLOW_SHIFT;
            RATIO_FULL,
            RATIO_RSVD: shift = 0;
            default:    shift = 0;
        endcase
        base = FIELD_LSB + int'(pos);
        if (base > shift) begin
            idx = IDX_W'(base - shift);
        end else begin
            idx = '0;
        end
    end

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FIELD_LSB = 10,
    parameter int unsigned FIELD_W   = 9,
    parameter int unsigned CNT_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        clk_ratio,
    output logic              beep
);
    import beep_tone_pkg::*;

    localparam int unsigned IDX_W = $clog2(CNT_W);

    logic               en_q;
    logic [FIELD_W-1:0] field_q;
    logic               ph_q;
    logic [CNT_W-1:0]   cnt_q;
    ratio_e             ratio_q;
    logic [FIELD_W-1:0] sel_onehot;
    logic               sel_valid;
    logic [IDX_W-1:0]   idx;
    tone_state_e        state_q;
    tone_state_e        state_d;
    logic               beep_q;

    beep_cfg_regs #(
        .DATA_W   (DATA_W),
        .FIELD_LSB(FIELD_LSB),
        .FIELD_W  (FIELD_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .en_q   (en_q),
        .field_q(field_q)
    );

    beep_free_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .ph_q (ph_q),
        .cnt_q(cnt_q)
    );

    beep_bit_select #(
        .FIELD_W  (FIELD_W),
        .FIELD_LSB(FIELD_LSB),
        .CNT_W    (CNT_W)
    ) u_sel (
        .field     (field_q),
        .ratio     (ratio_q),
        .sel_onehot(sel_onehot),
        .sel_valid (sel_valid),
        .idx       (idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= RATIO_FULL;
        end else begin
            ratio_q <= ratio_e'(clk_ratio);
        end
    end

    // next state: mute, no pitch, play
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_SILENT, ST_TONE: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                end else if (!sel_valid) begin
                    state_d = ST_SILENT;
                end else begin
                    state_d = ST_TONE;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beep_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF:    beep_q <= 1'b0;
                ST_SILENT: beep_q <= 1'b0;
                ST_TONE:   beep_q <= cnt_q[idx];
                default:   beep_q <= 1'b0;
            endcase
        end
    end

    assign beep = beep_q;

endmodule

// File: rtl/beep_tone_checker.sv
module beep_tone_checker #(
    parameter int unsigned FIELD_W = 9,
    parameter int unsigned CNT_W   = 20,
    localparam int unsigned IDX_W  = $clog2(CNT_W)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       beep,
    input beep_tone_pkg::tone_state_e state_q,
    input logic                       ph_q,
    input logic [CNT_W-1:0]           cnt_q,
    input logic [FIELD_W-1:0]         field_q,
    input logic [FIELD_W-1:0]         sel_onehot,
    input logic [IDX_W-1:0]           idx
);
    import beep_tone_pkg::*;

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q |=> cnt_q == $past(cnt_q) + 1'b1);

    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_q |=> $stable(cnt_q));

    assert_off_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OFF |=> !beep);

    assert_empty_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SILENT |=> !beep);

    assert_single_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot));

    assert_pick_in_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_onehot & field_q) == sel_onehot);

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(CNT_W));

    assert_rise_needs_tone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beep) |-> $past(state_q == ST_TONE));

endmodule

bind beep_tone_gen beep_tone_checker #(
    .FIELD_W(FIELD_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .beep      (beep),
    .state_q   (state_q),
    .ph_q      (ph_q),
    .cnt_q     (cnt_q),
    .field_q   (field_q),
    .sel_onehot(sel_onehot),
    .idx       (idx)
);

// File: tb/tb_beep_tone_gen.sv
module tb_beep_tone_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  clk_ratio = 2'b00;
    logic        beep;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    beep_tone_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clk_ratio(clk_ratio),
        .beep     (beep)
    );

    always #5 clk = ~clk;

    always @(negedge clk) cyc++;

    function automatic int exp_half(input logic [8:0] field, input logic [1:0] ratio);
        int k;
        int sh;
        k = -1;
        for (int i = 8; i >= 0; i--) begin
            if (field[i]) k = 10 + i;
        end
        if (k < 0) return 0;
        sh = (ratio == 2'b01) ? 1 : (ratio == 2'b10) ? 5 : 0;
        k = (k > sh) ? k - sh : 0;
        return 1 << (k + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_level(input logic lvl, input int lim, output int n);
        n = 0;
        while (beep !== lvl && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(input int h, input string req);
        int n;
        int hi;
        int lo;
        int lim;
        lim = 4 * h + 64;
        repeat (4) @(negedge clk);
        wait_level(1'b0, lim, n);
        wait_level(1'b1, lim, n);
        wait_level(1'b0, lim, hi);
        wait_level(1'b1, lim, lo);
        check(hi == h, {req, " high time"}, hi, h);
        check(lo == h, {req, " low time"}, lo, h);
    endtask

    task automatic stays_low(input int n, input string req);
        int highs;
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (beep !== 1'b0) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int t0;
        int tf;
        int n;
        int h;
        void'($urandom(32'd4711));
        clk_ratio = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, output low
        stays_low(20, "R1 reset low");

        // R2: write with bit0 clear and other bits set leaves tone off
        wr(1'b1, 32'h1 << 10);
        wr(1'b0, 32'hFFFF_FFFE);
        stays_low(300, "R2 bit0 clear mutes");

        // R5: bit 10 at full speed, period 4096
        wr(1'b0, 32'h1);
        measure(2048, "R5 bit10 full");

        // R3: reserved bits of the select write ignored
        clk_ratio = 2'b10;
        wr(1'b1, 32'hFFF8_03FF | (32'h1 << 11));
        measure(exp_half(9'b000000010, 2'b10), "R3 reserved ignored");

        // R6: half speed, bit 11 -> bit 10
        clk_ratio = 2'b01;
        wr(1'b1, 32'h1 << 11);
        measure(2048, "R6 half ratio");

        // R6: code 11 treated as full
        clk_ratio = 2'b11;
        wr(1'b1, 32'h1 << 10);
        measure(2048, "R6 code11 full");

        // R7: 1/32 speed, bit 16 -> bit 11
        clk_ratio = 2'b10;
        wr(1'b1, 32'h1 << 16);
        measure(4096, "R7 slow ratio");

        // R8: field 0b110 -> lowest is bit 11, slow -> bit 6
        wr(1'b1, 32'h6 << 10);
        measure(128, "R8 lowest set bit");

        // R9: empty field while enabled
        wr(1'b1, 32'h0);
        stays_low(600, "R9 empty field low");

        // R10: mute keeps counter phase, bit 10 slow -> bit 5, H=64
        wr(1'b1, 32'h1 << 10);
        measure(64, "R10 pre-mute tone");
        t0 = cyc;
        wr(1'b0, 32'h0);
        repeat (2) @(negedge clk);
        stays_low(100, "R10 muted low");
        wr(1'b0, 32'h1);
        wait_level(1'b1, 400, n);
        wait_level(1'b0, 400, n);
        tf = cyc;
        check(((tf - t0) % 128) == 64, "R10 R4 phase kept", (tf - t0) % 128, 64);

        // random: R5 R6 R7 R8 with reserved garbage
        for (int it = 0; it < 10; it++) begin
            logic [8:0] fld;
            int pos;
            logic [1:0] r;
            r = ($urandom % 2) ? 2'b10 : 2'b01;
            pos = (r == 2'b10) ? int'($urandom % 5) : 0;
            fld = 9'(($urandom << pos) | (1 << pos));
            clk_ratio = r;
            wr(1'b1, ({23'h0, fld} << 10) | ($urandom & 32'hFFF8_03FF));
            h = exp_half(fld, r);
            measure(h, "R8 random field");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule